// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block is a master for a synchronous serial link. A host sets it up through a small write port: the clock polarity, the bit order, the length of each half of the serial clock period, the number of bits to move, and the outgoing word. It then issues a start command. The port produces the serial clock and shifts the word out of one end of its single 16-bit data register. It shifts the bits it receives into the other end of that same register. When the last bit has been shifted, the received word is in the register and an interrupt request is raised.

The serial clock is timed in strobes of an external timebase, not in system clock cycles. Each half of the clock period lasts a programmed number of strobes, so the bit rate follows the timebase rather than the core clock. Outgoing data changes on one clock edge. Incoming data is captured on the other edge, called the valid edge.

Top module: `shift_port`

## Requirements
- R1: After reset, `busy`, `irq`, `data_q` and `sdo` are all 0 and `sclk` is 1. The reset configuration is polarity 0, LSB first, half period 1 and size field 0.
- R2: A write with `wr_en` high stores `wr_data` while `busy` is low. Address 0 holds polarity in bit 0 and direction in bit 1. Address 1 holds the half period. Address 2 holds the size, bits 4:0. Address 3 holds the data register, which `data_q` shows. Address 4 is the command word: bit 0 starts a transfer and raises `busy` in the next cycle.
- R3: Polarity 1 makes the rising `sclk` edge the valid edge, and polarity 0 makes the falling edge the valid edge. While idle, and at the end of each transfer, `sclk` rests at the inverse of the polarity bit.
- R4: Each half of the `sclk` period lasts exactly the programmed number of `tick` strobes. A half period of 0 acts as 1. Only cycles with `tick` high advance the timing, and values up to 0x8000 are supported.
- R5: With direction 0 (LSB first), `sdo` shows `data_q[0]`. On each changing edge the register shifts right, and the bit captured from `sdi` enters at bit 15.
- R6: With direction 1 (MSB first), `sdo` shows `data_q[15]`. On each changing edge the register shifts left, and the captured bit enters at bit 0.
- R7: `sdi` is captured on the valid edge. The register shifts, and `sdo` changes, only on the following changing edge.
- R8: A transfer moves exactly the programmed number of bits, 1 to 16. A size of 0, or of more than 16, moves 16 bits.
- R9: In the cycle the last bit is shifted, `busy` falls and `irq` rises. `irq` then stays high until a write to address 4 with bit 1 set clears it.
- R10: While `busy` is high, start commands and writes to addresses 0 to 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Single-cycle timebase strobe |
| wr_en | input | 1 | Host write enable |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 16 | Host write data |
| sdi | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Transfer-complete interrupt request |
| data_q | output | 16 | Shift/data register contents |

## Verification
A bad half-period counter appears at the very next pair of `sclk` edges, because the spacing between edges inside a transfer no longer equals the half period times the strobe spacing. A bad bit counter or bad clamp logic shows up when `busy` falls: the number of valid edges and the final word in `data_q` both differ from the expected values. A wrong shift direction, or capture on the wrong edge, corrupts `sdo` at the first valid edge that follows and leaves the wrong received bits in `data_q`. An `irq` that clears too early is visible a few cycles after completion.

// File: rtl/shift_port.sv
module shift_port #(
  parameter int DW = 16,
  parameter int HW = 16,
  localparam int WW = (DW > HW) ? DW : HW,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [WW-1:0] wr_data,
  input  logic          sdi,
  output logic          sclk,
  output logic          sdo,
  output logic          busy,
  output logic          irq,
  output logic [DW-1:0] data_q
);

  logic          pol, dir, sbit;
  logic [HW-1:0] half, hcnt;
  logic [CW-1:0] size, bcnt;

  wire [HW-1:0] half_eff  = (half == '0) ? HW'(1) : half;
  wire [CW-1:0] size_eff  = (size == '0 || size > CW'(DW)) ? CW'(DW) : size;
  wire          wr_idle   = wr_en & ~busy;
  wire          start     = wr_idle & (wr_addr == 3'd4) & wr_data[0];
  wire          irq_clr   = wr_en & (wr_addr == 3'd4) & wr_data[1];
  wire          edge_ev   = busy & tick & (hcnt == half_eff - HW'(1));
  wire          valid_ev  = edge_ev & (sclk != pol);
  wire          change_ev = edge_ev & (sclk == pol);

  assign sdo = dir ? data_q[DW-1] : data_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol    <= 1'b0;
      dir    <= 1'b0;
      half   <= HW'(1);
      size   <= '0;
      data_q <= '0;
      busy   <= 1'b0;
      irq    <= 1'b0;
      sclk   <= 1'b1;
      hcnt   <= '0;
      bcnt   <= '0;
      sbit   <= 1'b0;
    end else begin
      if (wr_idle) begin
        case (wr_addr)
          3'd0: {dir, pol} <= wr_data[1:0];
          3'd1: half       <= wr_data[HW-1:0];
          3'd2: size       <= wr_data[CW-1:0];
          3'd3: data_q     <= wr_data[DW-1:0];
          default: ;
        endcase
      end

      if (start) begin
        busy <= 1'b1;
        bcnt <= size_eff;
        hcnt <= '0;
      end else if (busy && tick) begin
        hcnt <= edge_ev ? '0 : hcnt + HW'(1);
      end

      if (!busy)        sclk <= ~pol;
      else if (edge_ev) sclk <= ~sclk;

      if (valid_ev) sbit <= sdi;

      if (irq_clr) irq <= 1'b0;

      if (change_ev) begin
        data_q <= dir ? {data_q[DW-2:0], sbit} : {sbit, data_q[DW-1:1]};
        bcnt   <= bcnt - CW'(1);
        if (bcnt == CW'(1)) begin
          busy <= 1'b0;
          irq  <= 1'b1;
        end
      end
    end
  end

endmodule

module shift_port_chk #(
  parameter int DW = 16,
  parameter int HW = 16,
  localparam int CW = $clog2(DW + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic          sclk,
  input logic          busy,
  input logic          irq,
  input logic          pol,
  input logic [CW-1:0] size,
  input logic [CW-1:0] bcnt,
  input logic [DW-1:0] data_q
);

  assert_done_raises_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  assert_end_at_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> sclk != pol);

  assert_sclk_paced_by_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(sclk)) |-> $past(tick));

  assert_bit_count_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt >= CW'(1) && bcnt <= CW'(DW)));

  assert_shift_on_change_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(data_q)) |-> sclk != pol);

  assert_size_locked_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_addr == 3'd2) |=> $stable(size));

endmodule

bind shift_port shift_port_chk #(.DW(DW), .HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .sclk(sclk), .busy(busy), .irq(irq), .pol(pol), .size(size),
  .bcnt(bcnt), .data_q(data_q)
);

// File: tb/sim_shift_port.sv
`timescale 1ns/1ps
module sim_shift_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic sdi = 1'b0;
  logic sclk, sdo, busy, irq;
  logic [15:0] data_q;

  always #2.5 clk = ~clk;

  shift_port u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sdi(sdi), .sclk(sclk), .sdo(sdo), .busy(busy), .irq(irq),
    .data_q(data_q));

  int checks = 0;
  int errors = 0;
  int tdiv = 1;
  int tph = 0;

  bit exp_q[$];
  bit pol_tb = 1'b0;
  bit dir_tb = 1'b0;
  bit in_xfer = 1'b0;
  bit first_edge = 1'b1;
  logic prev_sclk = 1'b1;
  logic [15:0] rxv = '0;
  int rx_i = 0;
  int since = 0;
  int exp_gap = 1;
  int edges = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (tph + 1 >= tdiv) tph = 0; else tph++;
    tick = (tph == 0);
  end

  // monitor: pops expected serial bits at each valid edge
  always @(negedge clk) begin
    since++;
    if (sclk !== prev_sclk) begin
      if (in_xfer) begin
        if (!first_edge) chk(since == exp_gap, "R4 edge spacing", since, exp_gap);
        first_edge = 1'b0;
        since = 0;
        if (sclk == pol_tb) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R8 extra valid edge", edges + 1, edges);
          end else begin
            bit e;
            e = exp_q.pop_front();
            chk(sdo == e, dir_tb ? "R6 sdo bit" : "R5 sdo bit", int'(sdo), int'(e));
          end
          edges++;
          rx_i++;
          sdi = (rx_i < 16) ? rxv[rx_i] : 1'b0;
        end
      end
      prev_sclk = sclk;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: configures, pushes expected bits, starts, checks completion
  task automatic xfer(input bit p, input bit d, input int hp, input int sz,
                      input logic [15:0] tx, input logic [15:0] rx, input int td,
                      input bit poke);
    int n;
    int t;
    logic [15:0] m;
    n = (sz == 0 || sz > 16) ? 16 : sz;
    m = tx;
    wr(3'd0, {14'd0, d, p});
    wr(3'd1, 16'(hp));
    wr(3'd2, 16'(sz));
    wr(3'd3, tx);
    tdiv = td; pol_tb = p; dir_tb = d; rxv = rx; rx_i = 0; sdi = rx[0];
    exp_q.delete();
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(d ? m[15] : m[0]);
      m = d ? {m[14:0], rx[i]} : {rx[i], m[15:1]};
    end
    exp_gap = ((hp == 0) ? 1 : hp) * td;
    edges = 0; first_edge = 1'b1; since = 0; in_xfer = 1'b1;
    wr(3'd4, 16'h0001);
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      wr(3'd3, 16'hA5A5);
      wr(3'd0, {14'd0, ~d, ~p});
      wr(3'd2, 16'd3);
      wr(3'd4, 16'h0001);
    end
    t = 0;
    while (!irq && t < 100000) begin
      @(negedge clk);
      t++;
    end
    chk(irq == 1'b1, "R9 irq at end", int'(irq), 1);
    chk(busy == 1'b0, "R9 busy clear at end", int'(busy), 0);
    chk(data_q == m, poke ? "R10 data after ignored writes" : "R7 received word",
        int'(data_q), int'(m));
    chk(edges == n, "R8 bit count", edges, n);
    chk(sclk == ~p, "R3 idle level after transfer", int'(sclk), int'(~p));
    in_xfer = 1'b0;
    repeat (5) @(negedge clk);
    chk(irq == 1'b1 && busy == 1'b0, "R9 irq held, R10 no restart",
        int'({irq, busy}), 2);
    wr(3'd4, 16'h0002);
    chk(irq == 1'b0, "R9 irq cleared", int'(irq), 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && irq == 0, "R1 reset flags", int'({busy, irq}), 0);
    chk(sclk == 1'b1, "R1 reset sclk", int'(sclk), 1);
    chk(data_q == 16'h0 && sdo == 1'b0, "R1 reset data", int'(data_q), 0);

    wr(3'd3, 16'h1234);
    chk(data_q == 16'h1234, "R2 data write", int'(data_q), 16'h1234);
    wr(3'd0, 16'h0001);
    @(negedge clk);
    chk(sclk == 1'b0, "R3 idle low for polarity 1", int'(sclk), 0);

    xfer(1'b0, 1'b0, 2, 8, 16'h00C5, 16'h5A3C, 1, 1'b0);
    xfer(1'b1, 1'b1, 3, 16, 16'hB6E1, 16'h7F02, 3, 1'b0);
    xfer(1'b0, 1'b0, 1, 0, 16'h8001, 16'hFFFF, 1, 1'b0);
    xfer(1'b1, 1'b0, 2, 20, 16'h3C3C, 16'h0F0F, 2, 1'b0);
    xfer(1'b0, 1'b1, 0, 1, 16'h8000, 16'h0001, 1, 1'b0);
    xfer(1'b1, 1'b1, 4, 6, 16'hF00D, 16'h002A, 1, 1'b1);
    xfer(1'b1, 1'b0, 32768, 1, 16'h0001, 16'h0000, 1, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule